// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Bank

This block controls one eight-pin general-purpose parallel port. Software sees four eight-bit registers on a simple synchronous bus with a two-bit address: an output latch, a pullup-enable mask, a slew-limit mask and a direction mask. On the pad side the block drives, for each pin, an output value, an output enable, a pullup request and a slew-limit request. It also takes the raw pad level back in through a two-flop synchronizer.

Reads go through a two-state response machine. `ST_IDLE` moves to `ST_RESP` when `rd_en` is high. `ST_RESP` stays in `ST_RESP` while `rd_en` stays high and returns to `ST_IDLE` when it drops. `rvalid` is high in `ST_RESP`. A data read is assembled bit by bit. Pins set as outputs return the latch value. Pins set as inputs return the synchronized pad level. The pad-control outputs are gated by direction: pullups only on inputs, slew limiting only on outputs.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset all four registers are zero. `pad_oe`, `pad_out`, `pad_pull`, `pad_slew` and `rvalid` are all 0.
- R2: A write with `wr_en` high stores `wdata` in the register chosen by `addr`: 0 = output latch, 1 = pullup mask, 2 = slew mask, 3 = direction mask. Reads of addresses 1, 2 and 3 return the stored value whatever the direction.
- R3: A read of address 0 returns, for each bit, the latch bit where the direction bit is 1, and the synchronized pad bit where it is 0.
- R4: A write to address 0 stores all eight bits, including the bits of pins that are currently inputs.
- R5: `pad_oe` equals the direction mask. `pad_out` equals the latch on pins whose direction bit is 1 and is 0 on all other pins.
- R6: `pad_pull` is the pullup mask ANDed with the inverted direction mask, so it is never 1 on an output pin.
- R7: `pad_slew` is the slew mask ANDed with the direction mask, so it has no effect on an input pin.
- R8: A change on `pad_in` becomes visible in data reads only after two clock edges. A read sampled at the first edge after the change still returns the old level.
- R9: When a pin's direction changes from input to output, the pin drives the stored latch value from the cycle after the direction write. No new data write is needed.
- R10: `rvalid` is high in exactly the cycle after each cycle in which `rd_en` is high. `rdata` then holds the register contents as they were before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with rvalid |
| rvalid | output | 1 | Read response valid |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pull | output | 8 | Pad pullup enables |
| pad_slew | output | 8 | Pad slew-limit enables |

## Verification
A read and a write can hit the same register in the same cycle. The bench provokes this by raising `rd_en` and `wr_en` together on the same address, for both the direction mask and the output latch. It then expects the returned value to be the pre-write contents, while the pad outputs already show the new value one cycle later. A second collision is a change on `pad_in` in the same cycle as a data read. That read is judged against the old synchronized level, and a later read against the new one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 2;
    localparam int NREGS  = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LATCH = 2'd0,
        SEL_PULL  = 2'd1,
        SEL_SLEW  = 2'd2,
        SEL_DIR   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain[s] <= '0;
                else if (s == 0)
                    chain[s] <= din;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      pull_q,
    output logic [W-1:0]      slew_q,
    output logic [W-1:0]      dir_q
);
    logic [W-1:0] bank [NREGS];

    genvar r;
    generate
        for (r = 0; r < NREGS; r++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bank[r] <= '0;
                else if (wr_en && addr == ADDR_W'(r))
                    bank[r] <= wdata;
            end
        end
    endgenerate

    assign latch_q = bank[SEL_LATCH];
    assign pull_q  = bank[SEL_PULL];
    assign slew_q  = bank[SEL_SLEW];
    assign dir_q   = bank[SEL_DIR];

    // R4: a write to the latch lands in every bit regardless of direction
    p_latch_all_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_LATCH) |=> latch_q == $past(wdata));
    // R2: a write to the direction mask is stored unchanged
    p_dir_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_DIR) |=> dir_q == $past(wdata));
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl #(
    parameter int W = 8
) (
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] pull_q,
    input  logic [W-1:0] slew_q,
    input  logic [W-1:0] dir_q,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pull,
    output logic [W-1:0] pad_slew
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pin
            always_comb begin
                pad_oe[i]   = dir_q[i];
                pad_out[i]  = dir_q[i] & latch_q[i];
                pad_pull[i] = pull_q[i] & ~dir_q[i];
                pad_slew[i] = slew_q[i] & dir_q[i];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    output logic              rvalid,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pull,
    output logic [PORT_W-1:0] pad_slew
);
    logic [PORT_W-1:0] latch_q, pull_q, slew_q, dir_q, pin_sync;
    logic [PORT_W-1:0] rd_mux;
    rd_state_e         state, state_nx;

    gpio_sync #(.W(PORT_W), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync)
    );

    gpio_regs #(.W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .latch_q(latch_q), .pull_q(pull_q), .slew_q(slew_q), .dir_q(dir_q)
    );

    gpio_padctl #(.W(PORT_W)) u_pad (
        .latch_q(latch_q), .pull_q(pull_q), .slew_q(slew_q), .dir_q(dir_q),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull), .pad_slew(pad_slew)
    );

    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_LATCH: rd_mux = (dir_q & latch_q) | (~dir_q & pin_sync);
            SEL_PULL:  rd_mux = pull_q;
            SEL_SLEW:  rd_mux = slew_q;
            SEL_DIR:   rd_mux = dir_q;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = rd_en ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = rd_en ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rdata <= '0;
        end else begin
            state <= state_nx;
            if (rd_en)
                rdata <= rd_mux;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE: rvalid = 1'b0;
            ST_RESP: rvalid = 1'b1;
        endcase
    end

    // R10: every read strobe is answered on the next cycle, and only then
    p_resp_follows_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    p_no_spurious_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);
    // R6: no pullup on a driven pin
    p_no_pull_on_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull & pad_oe) == '0);
    // R7: no slew limiting on a pin that is not driven
    p_no_slew_on_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_slew & ~pad_oe) == '0);
    // R5: undriven pins present zero on pad_out
    p_undriven_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);
    // R9: a latch write shows up on enabled pins in the next cycle
    p_latch_to_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_LATCH && !(rd_en && 1'b0)) |=> ((pad_out ^ $past(wdata)) & pad_oe) == '0);
endmodule

// File: tb/tb_gpio_port_bank.sv
module tb_gpio_port_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0, rdata, pad_in = '0;
    logic       rvalid;
    logic [7:0] pad_out, pad_oe, pad_pull, pad_slew;

    int total = 0, bad = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    gpio_port_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull), .pad_slew(pad_slew)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data whenever a response appears
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) check("R10 unexpected rvalid", 8'h1, 8'h0);
            else check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp); tag_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rw(logic [1:0] a, logic [7:0] d, logic [7:0] exp_old, string req);
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        exp_q.push_back(exp_old); tag_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog", 8'h1, 8'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 oe", pad_oe, 8'h00);
        check("R1 out", pad_out, 8'h00);
        check("R1 pull", pad_pull, 8'h00);
        check("R1 slew", pad_slew, 8'h00);
        check("R1 rvalid", {7'b0, rvalid}, 8'h00);
        @(negedge clk) rst_n = 1'b1;
        rd(2'd3, 8'h00, "R1 dir reads zero");
        rd(2'd1, 8'h00, "R1 pull reads zero");

        // R4 latch write while every pin is input; R3 reads show pad level
        pad_in = 8'h3C;
        wr(2'd0, 8'hA5);
        repeat (3) @(negedge clk);
        rd(2'd0, 8'h3C, "R3 all inputs read pad");
        check("R4 not driven yet", pad_out, 8'h00);

        // R2 pull and slew stored, gated by direction (R6, R7)
        wr(2'd1, 8'hF0);
        wr(2'd2, 8'h0F);
        check("R6 pull on inputs", pad_pull, 8'hF0);
        check("R7 slew off on inputs", pad_slew, 8'h00);

        // R9 turn low nibble to outputs: stored latch appears at once
        wr(2'd3, 8'h0F);
        check("R9 out after dir", pad_out, 8'h05);
        check("R5 oe equals dir", pad_oe, 8'h0F);
        check("R6 pull gated", pad_pull, 8'hF0);
        check("R7 slew gated", pad_slew, 8'h0F);
        rd(2'd0, 8'h35, "R3 mixed read");
        rd(2'd1, 8'hF0, "R2 pull readback");
        rd(2'd2, 8'h0F, "R2 slew readback");

        // R8 pad change visible only after two edges
        @(negedge clk);
        pad_in = 8'hC3; rd_en = 1'b1; addr = 2'd0;
        exp_q.push_back(8'h35); tag_q.push_back("R8 old level at first edge");
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        rd(2'd0, 8'hC5, "R8 new level after sync");

        // R10 collisions: read returns pre-write contents
        rw(2'd3, 8'hF0, 8'h0F, "R10 dir collision old value");
        check("R5 oe after collision", pad_oe, 8'hF0);
        check("R5 out after collision", pad_out, 8'hA0);
        check("R6 pull off on outputs", pad_pull, 8'h00);
        rw(2'd0, 8'h5A, 8'hA3, "R10 latch collision old value");
        check("R4 out after latch write", pad_out, 8'h50);
        rd(2'd3, 8'hF0, "R2 dir readback");

        // back-to-back reads keep rvalid high
        @(negedge clk);
        rd_en = 1'b1; addr = 2'd2;
        exp_q.push_back(8'h0F); tag_q.push_back("R10 b2b first");
        @(negedge clk);
        addr = 2'd1;
        exp_q.push_back(8'hF0); tag_q.push_back("R10 b2b second");
        @(negedge clk);
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 queue drained", 8'(exp_q.size()), 8'h00);
        check("R10 rvalid idle", {7'b0, rvalid}, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule